// File: doc/BRIEF.md
# Power Averager and Update Decimator

This block sits at the front of a gain-control loop. It receives one unsigned power value per valid cycle (the squared magnitude of an I/Q sample) and reduces the stream in two stages. First it averages a short run of one to four consecutive values. Then it adds a programmable number of those averages, from 1 to 4096, in an integrate-and-dump accumulator. Each dump is shifted right by a programmable amount, clamped to the output width and presented for one cycle with a valid strobe. The loop error computation that consumes the result is outside this block.

Configuration comes as a 6-bit control field and a 12-bit ratio field. The block samples them only at a block boundary, so that one output is never built from two settings. A bypass input skips both stages and forwards the upper 16 bits of every 24-bit input straight to the output.

Top module: `pwr_avg_decim`

## Requirements
- R1: Control bits [1:0] hold code c. The first stage averages N = c+1 consecutive valid inputs and forms floor(sum/N) as one average per N inputs.
- R2: Ratio field value r sets R = r+1 averages per dump. `out_vld` is high for exactly one cycle, in the cycle after the clock edge that takes the N*R-th valid input of a block, and it is low at every other time in that block.
- R3: The dumped value is the sum of the R averages shifted right by the scale held in control bits [5:2]. If the shifted value does not fit in 16 bits, the output is 0xFFFF.
- R4: For N = 3 (code 2) the average equals floor(sum/3) exactly for all 24-bit inputs. It is formed by a multiply with a reciprocal constant.
- R5: While `cfg_bypass` is 1, each valid input gives `out_vld` = 1 in the next cycle with `out_pwr` equal to input bits [23:8]. Any partial average or partial accumulation is discarded.
- R6: A change of the control or ratio field in the middle of a block does not affect that block. The new values apply from the first input after the next dump, bypass or reset.
- R7: After reset, `out_vld` and `out_pwr` are 0 and no partial state remains. A block that starts after reset gives the same result as one from a clean start.
- R8: Cycles with `pwr_vld` = 0 neither advance the averaging or dump counts nor produce an output, whatever `pwr_in` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_vld | input | 1 | Input power value valid |
| pwr_in | input | 24 | Unsigned power value |
| cfg_ctl | input | 6 | [1:0] averaging code, [5:2] right-shift scale |
| cfg_ratio | input | 12 | Dump ratio minus one |
| cfg_bypass | input | 1 | Forward input bits [23:8] directly |
| out_vld | output | 1 | Output valid, one cycle per dump or bypassed input |
| out_pwr | output | 16 | Scaled and clamped power, held between strobes |

## Verification
The main path is tested with blocks that cover all four averaging codes. Some blocks are constant, which shows whether the ratio and the shift are counted correctly. Others are ramps whose sums are not multiples of N, which shows whether each average is floored per group or only once over the total. Runs near full scale, with the largest ratio and wrapping ramps, separate exact division by three and saturation from plain truncation. Idle gaps with junk on the data input and a control change in the middle of a block separate correct gating and boundary latching from counters that run free.

// File: rtl/pwr_avg_pkg.sv
package pwr_avg_pkg;
    localparam int IN_W_DEF    = 24;
    localparam int OUT_W_DEF   = 16;
    localparam int RATIO_W_DEF = 12;
    localparam int SCALE_W     = 4;
    localparam int AVG_W       = 2;

    typedef struct packed {
        logic [SCALE_W-1:0] scale;
        logic [AVG_W-1:0]   avg_code;
    } ctl_t;
endpackage

// File: rtl/pwr_avg_stage.sv
module pwr_avg_stage #(
    parameter int IN_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush_i,
    input  logic            vld_i,
    input  logic [IN_W-1:0] smp_i,
    input  logic [1:0]      code_i,
    output logic            avg_vld_o,
    output logic [IN_W-1:0] avg_o,
    output logic            idle_o
);
    localparam int SUM_W  = IN_W + 2;
    localparam int SH     = IN_W + 4;
    localparam int PROD_W = SUM_W + SH;
    localparam int XW     = SUM_W + 2;
    localparam logic [SH-1:0] K3 = SH'(((64'd1 << SH) / 3) + 1);

    typedef struct packed {
        logic [1:0]       cnt;
        logic [SUM_W-1:0] sum;
    } st_t;

    st_t st_d, st_q;
    logic [SUM_W-1:0]  total;
    logic [PROD_W-1:0] prod;
    logic [SUM_W-1:0]  quo;

    always_comb begin
        st_d      = st_q;
        avg_vld_o = 1'b0;
        total     = st_q.sum + SUM_W'(smp_i);
        prod      = PROD_W'(total) * PROD_W'(K3);
        case (code_i)
            2'd0:    quo = total;
            2'd1:    quo = total >> 1;
            2'd2:    quo = SUM_W'(prod >> SH);
            default: quo = total >> 2;
        endcase
        avg_o = quo[IN_W-1:0];
        if (flush_i) begin
            st_d = '0;
        end else if (vld_i) begin
            if (st_q.cnt == code_i) begin
                avg_vld_o = 1'b1;
                st_d      = '0;
            end else begin
                st_d.cnt = st_q.cnt + 2'd1;
                st_d.sum = total;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idle_o = (st_q.cnt == 2'd0);

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != 2'd0) |-> (st_q.cnt <= code_i));

    assert_div3_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (avg_vld_o && code_i == 2'd2) |->
        ((XW'(avg_o) * XW'(3) <= XW'(total)) && (XW'(total) < XW'(avg_o) * XW'(3) + XW'(3))));
endmodule

// File: rtl/pwr_dump_stage.sv
module pwr_dump_stage #(
    parameter int IN_W    = 24,
    parameter int OUT_W   = 16,
    parameter int RATIO_W = 12,
    parameter int SCALE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic               avg_vld_i,
    input  logic [IN_W-1:0]    avg_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [SCALE_W-1:0] scale_i,
    input  logic               byp_vld_i,
    input  logic [OUT_W-1:0]   byp_dat_i,
    output logic               out_vld_o,
    output logic [OUT_W-1:0]   out_o,
    output logic               idle_o
);
    localparam int ACC_W = IN_W + RATIO_W;

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic [ACC_W-1:0]   acc;
        logic               vld;
        logic [OUT_W-1:0]   dat;
    } st_t;

    st_t st_d, st_q;
    logic [ACC_W-1:0] acc_sum;
    logic [ACC_W-1:0] shifted;
    logic [OUT_W-1:0] clamped;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        acc_sum  = st_q.acc + ACC_W'(avg_i);
        shifted  = acc_sum >> scale_i;
        clamped  = (|(shifted >> OUT_W)) ? '1 : shifted[OUT_W-1:0];
        if (flush_i) begin
            st_d.cnt = '0;
            st_d.acc = '0;
            if (byp_vld_i) begin
                st_d.vld = 1'b1;
                st_d.dat = byp_dat_i;
            end
        end else if (avg_vld_i) begin
            if (st_q.cnt == ratio_i) begin
                st_d.vld = 1'b1;
                st_d.dat = clamped;
                st_d.cnt = '0;
                st_d.acc = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                st_d.acc = acc_sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld_o = st_q.vld;
    assign out_o     = st_q.dat;
    assign idle_o    = (st_q.cnt == '0);

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= ratio_i);
endmodule

// File: rtl/pwr_avg_decim.sv
module pwr_avg_decim
    import pwr_avg_pkg::*;
#(
    parameter int IN_W    = IN_W_DEF,
    parameter int OUT_W   = OUT_W_DEF,
    parameter int RATIO_W = RATIO_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pwr_vld,
    input  logic [IN_W-1:0]            pwr_in,
    input  logic [SCALE_W+AVG_W-1:0]   cfg_ctl,
    input  logic [RATIO_W-1:0]         cfg_ratio,
    input  logic                       cfg_bypass,
    output logic                       out_vld,
    output logic [OUT_W-1:0]           out_pwr
);
    typedef struct packed {
        ctl_t               ctl;
        logic [RATIO_W-1:0] ratio;
    } act_t;

    act_t act_d, act_q, use_cfg;
    logic avg_idle, dump_idle, idle;
    logic avg_vld;
    logic [IN_W-1:0] avg_val;

    assign idle = avg_idle & dump_idle;

    always_comb begin
        use_cfg = idle ? act_t'{ctl: ctl_t'(cfg_ctl), ratio: cfg_ratio} : act_q;
        act_d   = act_q;
        if (pwr_vld && idle && !cfg_bypass) act_d = use_cfg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    pwr_avg_stage #(.IN_W(IN_W)) u_avg (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (cfg_bypass),
        .vld_i     (pwr_vld),
        .smp_i     (pwr_in),
        .code_i    (use_cfg.ctl.avg_code),
        .avg_vld_o (avg_vld),
        .avg_o     (avg_val),
        .idle_o    (avg_idle)
    );

    pwr_dump_stage #(
        .IN_W(IN_W), .OUT_W(OUT_W), .RATIO_W(RATIO_W), .SCALE_W(SCALE_W)
    ) u_dump (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (cfg_bypass),
        .avg_vld_i (avg_vld),
        .avg_i     (avg_val),
        .ratio_i   (use_cfg.ratio),
        .scale_i   (use_cfg.ctl.scale),
        .byp_vld_i (pwr_vld & cfg_bypass),
        .byp_dat_i (pwr_in[IN_W-1 -: OUT_W]),
        .out_vld_o (out_vld),
        .out_o     (out_pwr),
        .idle_o    (dump_idle)
    );

    assert_bypass_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bypass && pwr_vld) |=> (out_vld && out_pwr == $past(pwr_in[IN_W-1 -: OUT_W])));

    assert_out_needs_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(pwr_vld));
endmodule

// File: tb/pwr_avg_decim_bench.sv
`timescale 1ns/1ps
module pwr_avg_decim_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_vld = 1'b0;
    logic [23:0] pwr_in = '0;
    logic [5:0]  cfg_ctl = '0;
    logic [11:0] cfg_ratio = '0;
    logic        cfg_bypass = 1'b0;
    logic        out_vld;
    logic [15:0] out_pwr;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pwr_avg_decim u_pwr_avg_decim (
        .clk(clk), .rst_n(rst_n), .pwr_vld(pwr_vld), .pwr_in(pwr_in),
        .cfg_ctl(cfg_ctl), .cfg_ratio(cfg_ratio), .cfg_bypass(cfg_bypass),
        .out_vld(out_vld), .out_pwr(out_pwr)
    );

    // ctl = scale*4 + averaging code
    localparam int     V_CTL  [8] = '{32, 17, 10, 27, 34, 0, 61, 51};
    localparam int     V_RAT  [8] = '{0, 2, 1, 5, 0, 3, 63, 20};
    localparam longint V_BASE [8] = '{64'h123456, 64'h1000, 64'hABCD, 64'h40000,
                                      64'h7FFFFF, 64'hFFFFFF, 64'h3, 64'h800000};
    localparam longint V_STEP [8] = '{0, 64'h333, 64'h101, 64'h1111,
                                      64'h400001, 0, 64'h9999, 7};
    localparam int     V_GAP  [8] = '{0, 1, 0, 2, 0, 0, 0, 1};

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic longint smp(input longint base, input longint step, input int i);
        return (base + longint'(i) * step) & 64'hFFFFFF;
    endfunction

    function automatic longint expect_blk(input int ctl, input int ratio,
                                          input longint base, input longint step);
        int n = (ctl & 3) + 1;
        longint total = 0;
        longint sh;
        for (int g = 0; g <= ratio; g++) begin
            longint s = 0;
            for (int j = 0; j < n; j++) s += smp(base, step, g * n + j);
            total += s / n;
        end
        sh = total >> ((ctl >> 2) & 15);
        return (sh > 65535) ? 65535 : sh;
    endfunction

    task automatic run_block(input int ctl, input int ratio, input longint base,
                             input longint step, input int gap, input int chg_at,
                             input int chg_ctl, input int chg_ratio, input string tag);
        int n = (ctl & 3) + 1;
        int total = n * (ratio + 1);
        bit early = 0;
        longint exp = expect_blk(ctl, ratio, base, step);
        cfg_ctl   = 6'(ctl);
        cfg_ratio = 12'(ratio);
        for (int i = 0; i < total; i++) begin
            if (i == chg_at) begin
                cfg_ctl   = 6'(chg_ctl);
                cfg_ratio = 12'(chg_ratio);
            end
            pwr_vld = 1'b1;
            pwr_in  = 24'(smp(base, step, i));
            @(negedge clk);
            pwr_vld = 1'b0;
            if (i != total - 1) begin
                if (out_vld) early = 1;
                for (int k = 0; k < gap; k++) begin
                    pwr_in = 24'(32'hA5A5A5 ^ (k * 32'h111111) ^ i);
                    @(negedge clk);
                    if (out_vld) early = 1;
                end
            end else begin
                check(out_vld === 1'b1, {tag, " strobe after last input"}, longint'(out_vld), 1);
                check(out_pwr === 16'(exp), {tag, " value"}, longint'(out_pwr), exp);
            end
        end
        check(!early, {tag, " R2 R8 no early strobe"}, longint'(early), 0);
    endtask

    initial begin
        #(150000 * 5);
        check(0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_vld === 1'b0 && out_pwr === 16'h0, "R7 reset state", longint'(out_pwr), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table of vectors: averaging codes, ratios, scales, gaps
        for (int v = 0; v < 8; v++)
            run_block(V_CTL[v], V_RAT[v], V_BASE[v], V_STEP[v], V_GAP[v], -1, 0, 0,
                      "R1 R2 R3 R4 table");

        // R6: mid-block change of config is deferred to the next block
        run_block(17, 3, 64'h2000, 64'h77, 0, 3, 58, 1, "R6 old config kept");
        run_block(58, 1, 64'h2000, 64'h77, 0, -1, 0, 0, "R6 new config applied");

        // R5: bypass discards a partial block and passes the upper bits
        cfg_ctl = 6'd17; cfg_ratio = 12'd2;
        for (int i = 0; i < 3; i++) begin
            pwr_vld = 1'b1; pwr_in = 24'hFFFFFF;
            @(negedge clk);
        end
        pwr_vld = 1'b0;
        cfg_bypass = 1'b1;
        @(negedge clk);
        check(out_vld === 1'b0, "R5 R8 bypass without valid", longint'(out_vld), 0);
        pwr_vld = 1'b1; pwr_in = 24'hABCDEF;
        @(negedge clk);
        check(out_vld === 1'b1 && out_pwr === 16'hABCD, "R5 bypass data", longint'(out_pwr), 64'hABCD);
        pwr_in = 24'h0012FF;
        @(negedge clk);
        check(out_vld === 1'b1 && out_pwr === 16'h0012, "R5 bypass second", longint'(out_pwr), 64'h12);
        pwr_vld = 1'b0; cfg_bypass = 1'b0;
        @(negedge clk);
        run_block(17, 2, 64'h100, 64'h10, 0, -1, 0, 0, "R5 fresh block after bypass");

        // R7: reset in the middle of a block
        cfg_ctl = 6'd3; cfg_ratio = 12'd1;
        for (int i = 0; i < 5; i++) begin
            pwr_vld = 1'b1; pwr_in = 24'h7FFFFF;
            @(negedge clk);
        end
        pwr_vld = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(out_vld === 1'b0 && out_pwr === 16'h0, "R7 mid-block reset", longint'(out_pwr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_block(3, 1, 64'h1234, 64'h55, 0, -1, 0, 0, "R7 clean block after reset");

        // R2 R3: largest ratio, result lands exactly on the output ceiling
        run_block(63, 4095, 64'h07FFF8, 0, 0, -1, 0, 0, "R2 R3 max ratio");
        run_block(63, 4095, 64'h080000, 0, 0, -1, 0, 0, "R3 saturation");

        // R4: three-sample average near full scale
        run_block(2, 0, 64'hFFFFFF, 64'hFFFFFF, 0, -1, 0, 0, "R4 full-scale thirds");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule